// File: doc/BRIEF.md
# Two-Compare Alternating PWM Timer Channel

This block is a single channel of a 16-bit up-counting timer that produces a pulse-width-modulated output. Two compare registers take turns against the counter. The first one sets how long the output stays low and the second sets how long it stays high. On each match the counter returns to zero, the output flag changes state and the other compare register becomes the active one. Each compare register has a shadow (preload) register. The shadow of one compare is copied in when the other compare matches, so software can change the duty cycle while the channel runs without producing a cut-short or stretched phase.

The counter advances on ticks from a power-of-two prescaler that divides the clock by 1 to 128. Besides alternating toggling, the output logic can be told to set the flag on a match, which gives a constant high (full duty), or to clear it on a match, which gives a constant low (zero duty). A force bit written together with the output enable drives the flag low at once. Software converts a period and pulse in ticks to compare values: the high count is pulse minus one and the low count is period minus pulse minus one, with either subtraction skipped when the value is already zero.

Top module: `altcmp_pwm`

## Requirements
- R1: After reset the output pin is low and the counter is stopped. The pin stays low with no register writes.
- R2: In toggle mode (control bits [1:0] = 0 or 3), with compare 1 (address 0) holding L and compare 2 (address 1) holding H, the output is high for (H+1) ticks and low for (L+1) ticks in each period.
- R3: Once started, the first phase is a low phase of (L+1) ticks, timed by compare 1.
- R4: Compare 2 reloads from preload 2 (address 3) only when compare 1 matches. A preload 2 write during a high phase leaves that phase unchanged and sets the length of the next high phase.
- R5: Compare 1 reloads from preload 1 (address 2) only when compare 2 matches.
- R6: In set mode (control bits [1:0] = 1), the flag goes high at the first match and stays high.
- R7: In clear mode (control bits [1:0] = 2), the flag goes low at the first match and stays low.
- R8: Writing the control register (address 4) with the force bit (bit 6) and the enable bit (bit 7) both set drives the flag low on the next clock edge, whatever state the counter is in.
- R9: The prescale select in control bits [4:2] divides the tick rate by 2^select, so every phase lasts (count+1)·2^select clocks.
- R10: Clearing the run bit (bit 5) freezes the counter and the output. Setting it again restarts the counter at zero with compare 1 active.
- R11: In toggle mode every match inverts the flag.
- R12: The pin equals the flag when the enable bit (bit 7) is set and is low when the enable bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 compare 1, 1 compare 2, 2 preload 1, 3 preload 2, 4 control |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM output pin |

## Verification
The hardest case to reach from the ports is a preload that lands in the middle of a running phase. Only then can the bench see whether the value waits for the opposite register's match or gets applied too early. The bench watches for a rising output edge and writes both preloads while that high phase is still running. It then measures four phases in a row: the unchanged high phase, a shortened low phase taken from preload 1, a shortened high phase taken from preload 2, and the low phase after it. A one-cycle timing error in either reload path changes one of these four widths.

// File: rtl/altcmp_pkg.sv
package altcmp_pkg;
  typedef enum logic [1:0] {
    OM_TOGGLE  = 2'd0,
    OM_SET     = 2'd1,
    OM_CLEAR   = 2'd2,
    OM_TOGGLE3 = 2'd3
  } outmode_e;

  localparam logic [2:0] A_CMP1 = 3'd0;
  localparam logic [2:0] A_CMP2 = 3'd1;
  localparam logic [2:0] A_PRE1 = 3'd2;
  localparam logic [2:0] A_PRE2 = 3'd3;
  localparam logic [2:0] A_CTRL = 3'd4;

  localparam int B_RUN   = 5;
  localparam int B_FORCE = 6;
  localparam int B_OEN   = 7;

  // terminal value of the prescale counter for a 2^sel divider
  function automatic int unsigned psc_mask(input int unsigned sel);
    return (32'd1 << sel) - 32'd1;
  endfunction

  // counter value after a tick: wrap on match, else step
  function automatic logic [15:0] cnt_next(input logic [15:0] c, input logic hit);
    return hit ? 16'd0 : c + 16'd1;
  endfunction
endpackage

// File: rtl/altcmp_prescale.sv
module altcmp_prescale #(
  parameter int PSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           start,
  input  logic [PSW-1:0] sel,
  output logic           tick
);
  localparam int PCW = (2 ** PSW) - 1;

  logic [PCW-1:0] pcnt;
  logic [PCW-1:0] mask;

  assign mask = PCW'(altcmp_pkg::psc_mask(32'(sel)));
  assign tick = run && (pcnt == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)              pcnt <= '0;
    else if (start || !run)  pcnt <= '0;
    else if (tick)           pcnt <= '0;
    else                     pcnt <= pcnt + PCW'(1);
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0) |=> (!tick || sel == '0)); // R9
endmodule

// File: rtl/altcmp_core.sv
module altcmp_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          start,
  input  logic          tick,
  input  logic          wr_cmp1,
  input  logic          wr_cmp2,
  input  logic          wr_pre1,
  input  logic          wr_pre2,
  input  logic [CW-1:0] wdata,
  output logic          match,
  output logic          act
);
  logic [CW-1:0] cnt, cmp1, cmp2, pre1, pre2;
  logic [CW-1:0] live_cmp;
  logic          hit_lo, hit_hi;

  assign live_cmp = act ? cmp2 : cmp1;
  assign match    = tick && (cnt == live_cmp);
  assign hit_lo   = match && !act;   // compare 1 event
  assign hit_hi   = match && act;    // compare 2 event

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      act <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      act <= 1'b0;
    end else if (tick) begin
      cnt <= CW'(altcmp_pkg::cnt_next(16'(cnt), match));
      if (match) act <= ~act;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp1 <= '0;
      cmp2 <= '0;
      pre1 <= '0;
      pre2 <= '0;
    end else begin
      if (wr_pre1) pre1 <= wdata;
      if (wr_pre2) pre2 <= wdata;
      if (wr_cmp1)     cmp1 <= wdata;
      else if (hit_hi) cmp1 <= pre1;
      if (wr_cmp2)     cmp2 <= wdata;
      else if (hit_lo) cmp2 <= pre2;
    end
  end

  AST_LOAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lo && !wr_cmp2) |=> (cmp2 == $past(pre2))); // R4
  AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_hi && !wr_cmp1) |=> (cmp1 == $past(pre1))); // R5
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> ($stable(cnt) && $stable(act))); // R10
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0 && !act)); // R10
endmodule

// File: rtl/altcmp_outflag.sv
module altcmp_outflag (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 match,
  input  logic                 force_low,
  input  altcmp_pkg::outmode_e mode,
  input  logic                 oen,
  output logic                 pin
);
  logic flag;

  always_ff @(posedge clk) begin
    if (!rst_n)         flag <= 1'b0;
    else if (force_low) flag <= 1'b0;
    else if (match) begin
      case (mode)
        altcmp_pkg::OM_SET:   flag <= 1'b1;
        altcmp_pkg::OM_CLEAR: flag <= 1'b0;
        default:              flag <= ~flag;
      endcase
    end
  end

  assign pin = flag & oen;

  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    force_low |=> !flag); // R8
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !force_low && (mode == altcmp_pkg::OM_TOGGLE || mode == altcmp_pkg::OM_TOGGLE3))
      |=> (flag != $past(flag))); // R11
  AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !force_low && mode == altcmp_pkg::OM_SET) |=> flag); // R6
  AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (match && mode == altcmp_pkg::OM_CLEAR) |=> !flag); // R7
endmodule

// File: rtl/altcmp_pwm.sv
module altcmp_pwm #(
  parameter int CW  = 16,
  parameter int PSW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_out
);
  import altcmp_pkg::*;

  localparam int SEL_LSB = 2;

  outmode_e       mode_q;
  logic [PSW-1:0] sel_q;
  logic           run_q, oen_q;

  logic ctrl_wr, start_evt, force_evt, tick, match, act;

  assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
  assign start_evt = ctrl_wr && wr_data[B_RUN] && !run_q;
  assign force_evt = ctrl_wr && wr_data[B_FORCE] && wr_data[B_OEN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= OM_TOGGLE;
      sel_q  <= '0;
      run_q  <= 1'b0;
      oen_q  <= 1'b0;
    end else if (ctrl_wr) begin
      mode_q <= outmode_e'(wr_data[1:0]);
      sel_q  <= wr_data[SEL_LSB +: PSW];
      run_q  <= wr_data[B_RUN];
      oen_q  <= wr_data[B_OEN];
    end
  end

  altcmp_prescale #(.PSW(PSW)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .start (start_evt),
    .sel   (sel_q),
    .tick  (tick)
  );

  altcmp_core #(.CW(CW)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .start   (start_evt),
    .tick    (tick),
    .wr_cmp1 (wr_en && wr_addr == A_CMP1),
    .wr_cmp2 (wr_en && wr_addr == A_CMP2),
    .wr_pre1 (wr_en && wr_addr == A_PRE1),
    .wr_pre2 (wr_en && wr_addr == A_PRE2),
    .wdata   (wr_data),
    .match   (match),
    .act     (act)
  );

  altcmp_outflag u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .match     (match),
    .force_low (force_evt),
    .mode      (mode_q),
    .oen       (oen_q),
    .pin       (pwm_out)
  );

  AST_MATCH_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> run_q); // R10
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> !pwm_out); // R1
  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !oen_q |-> !pwm_out); // R12
  AST_ACT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !start_evt) |=> (act != $past(act))); // R11
endmodule

// File: tb/tb_altcmp_pwm.sv
module tb_altcmp_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_out;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  altcmp_pwm dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  localparam logic [15:0] RUN = 16'h0020, FRC = 16'h0040, OEN = 16'h0080;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] ctrl(input int mode, input int sel, input bit run, input bit frc, input bit oen);
    return 16'(mode) | 16'(sel << 2) | (run ? RUN : 16'h0) | (frc ? FRC : 16'h0) | (oen ? OEN : 16'h0);
  endfunction

  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (pwm_out === lvl && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_level(input logic lvl);
    int n = 0;
    while (pwm_out !== lvl && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic measure(output int hi, output int lo);
    wait_level(1'b0);
    wait_level(1'b1);
    count_level(1'b1, hi);
    count_level(1'b0, lo);
  endtask

  // stop, force low, load values, start
  task automatic program_ch(input int lo, input int hi, input int sel, input int mode);
    wr(3'd4, ctrl(0, 0, 0, 1, 1));
    wr(3'd0, 16'(lo)); wr(3'd2, 16'(lo));
    wr(3'd1, 16'(hi)); wr(3'd3, 16'(hi));
    wr(3'd4, ctrl(mode, sel, 1, 0, 1));
  endtask

  task automatic t_reset;
    int n;
    check(pwm_out === 1'b0, "R1 pin after reset", int'(pwm_out), 0);
    count_level(1'b0, n);
    check(n >= 20 || n == 5000, "R1 pin idle low", n, 20);
  endtask

  task automatic t_toggle;
    int hi, lo, first;
    program_ch(3, 5, 0, 0);
    count_level(1'b0, first);
    check(first == 4, "R3 first low phase", first, 4);
    measure(hi, lo);
    check(hi == 6, "R2 high width", hi, 6);
    check(lo == 4, "R2 low width", lo, 4);
    program_ch(7, 2, 0, 3);
    measure(hi, lo);
    check(hi == 3 && lo == 8, "R11 toggle with code 3", hi * 100 + lo, 308);
  endtask

  task automatic t_preload;
    int a, b, c, d;
    program_ch(3, 5, 0, 0);
    wait_level(1'b0);
    wait_level(1'b1);
    wr(3'd3, 16'd2);
    wr(3'd1 + 3'd1, 16'd1);
    count_level(1'b1, a);
    a = a + 2;
    count_level(1'b0, b);
    count_level(1'b1, c);
    count_level(1'b0, d);
    check(a == 6, "R4 running high phase kept", a, 6);
    check(b == 2, "R5 low from preload 1", b, 2);
    check(c == 3, "R4 high from preload 2", c, 3);
    check(d == 2, "R5 next low", d, 2);
  endtask

  task automatic t_prescale;
    int hi, lo, first;
    program_ch(1, 1, 2, 0);
    count_level(1'b0, first);
    check(first == 8, "R9 first low div4", first, 8);
    measure(hi, lo);
    check(hi == 8 && lo == 8, "R9 div4 widths", hi * 1000 + lo, 8008);
    program_ch(0, 0, 7, 0);
    measure(hi, lo);
    check(hi == 128 && lo == 128, "R9 div128 widths", hi * 1000 + lo, 128128);
  endtask

  task automatic t_force;
    program_ch(3, 5, 0, 0);
    wait_level(1'b0);
    wait_level(1'b1);
    wr(3'd4, ctrl(0, 0, 1, 1, 1));
    check(pwm_out === 1'b0, "R8 force drives low", int'(pwm_out), 0);
  endtask

  task automatic t_stop;
    int diff = 0, first, hi;
    logic v;
    program_ch(3, 5, 0, 0);
    wait_level(1'b1);
    wr(3'd4, ctrl(0, 0, 0, 0, 1));
    v = pwm_out;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwm_out !== v) diff++;
    end
    check(diff == 0 && v === 1'b1, "R10 held while stopped", diff, 0);
    wr(3'd4, ctrl(0, 0, 0, 1, 1));
    wr(3'd4, ctrl(0, 0, 1, 0, 1));
    count_level(1'b0, first);
    count_level(1'b1, hi);
    check(first == 4 && hi == 6, "R10 restart at compare 1", first * 10 + hi, 46);
  endtask

  task automatic t_set_clear;
    int first, cnt_bad = 0, n;
    program_ch(2, 2, 0, 1);
    count_level(1'b0, first);
    check(first == 3, "R6 set at first match", first, 3);
    for (int i = 0; i < 40; i++) begin
      if (pwm_out !== 1'b1) cnt_bad++;
      @(negedge clk);
    end
    check(cnt_bad == 0, "R6 stays high", cnt_bad, 0);
    wr(3'd4, ctrl(2, 0, 0, 0, 1));
    repeat (10) @(negedge clk);
    check(pwm_out === 1'b1, "R10 stop keeps level", int'(pwm_out), 1);
    wr(3'd4, ctrl(2, 0, 1, 0, 1));
    count_level(1'b1, n);
    check(n == 3, "R7 clear at first match", n, 3);
    cnt_bad = 0;
    for (int i = 0; i < 40; i++) begin
      if (pwm_out !== 1'b0) cnt_bad++;
      @(negedge clk);
    end
    check(cnt_bad == 0, "R7 stays low", cnt_bad, 0);
  endtask

  task automatic t_oen;
    int n;
    program_ch(1, 1, 0, 1);
    repeat (6) @(negedge clk);
    check(pwm_out === 1'b1, "R12 enabled pin follows flag", int'(pwm_out), 1);
    wr(3'd4, ctrl(1, 0, 1, 0, 0));
    count_level(1'b0, n);
    check(n >= 20 || n == 5000, "R12 disabled pin low", n, 20);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_toggle;
    t_preload;
    t_prescale;
    t_force;
    t_stop;
    t_set_clear;
    t_oen;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule